// File: doc/BRIEF.md
# Packet Stream to Memory Descriptor Writer

This block moves data from a valid/ready packet stream into memory. A linked list of descriptors in memory drives it. Software writes the address of the first descriptor and sets the run bit. The engine then reads one four-word descriptor at a time and checks that hardware owns it. It writes each accepted stream beat as one 32-bit word, starting at the destination address. The transfer ends after a fixed byte count or at an end-of-packet beat. The engine then writes a status word back into the descriptor with ownership cleared, and follows the next-descriptor pointer.

A descriptor whose ownership bit is clear ends the chain. A chain that moves one packet therefore ends with a terminating descriptor. The stream's start-of-packet flag plays no part. An engine that is waiting for data waits without limit. A single simple memory master issues both the descriptor reads and the data and status writes, with one access outstanding at a time.

Top module: `s2m_dma_writer`

## Requirements
- R1: After synchronous active-high reset the engine is idle: `st_ready` and `mem_req` are low, and the control register and status register (busy bit0, done bit1) read 0.
- R2: When run (control register at csr address 0, bit0) is set while idle, the engine reads four words. The first descriptor address comes from csr address 1, and the words sit at byte offsets 0, 4, 8 and 12. They hold: destination address, next-descriptor address, length in bytes in bits [15:0], and control, where bit0 means hardware-owned and bit1 enables end-of-packet termination.
- R3: A fetched descriptor whose control bit0 is 0 writes nothing. The engine sets done, clears run and returns to idle.
- R4: Beat k of a transfer is written as one word to destination + 4*k. `st_ready` is high only while a descriptor is active and no memory write is pending.
- R5: A length of 0 keeps the transfer going until a beat with `st_eop` high is accepted. That beat is written and is the last one.
- R6: A nonzero length ends the transfer on the beat that brings the bytes written to at least the length. An end-of-packet beat ends it earlier only when control bit1 is set. With bit1 clear, end-of-packet is ignored.
- R7: `st_sop` has no effect on what is written or on the status.
- R8: An active descriptor with no stream data waits indefinitely, with `st_ready` high, busy set and no memory access.
- R9: At the end of a transfer the engine writes control word offset 12 before any further descriptor read. The word holds bits [31:16] = bytes written, bit9 = 1, bit8 = last beat ended the transfer by end-of-packet, bit1 = copy of the enable, bit0 = 0.
- R10: After the write-back, the engine fetches the descriptor at the next-descriptor address and processes it the same way.
- R11: Clearing run lets the current descriptor finish, including its write-back. The engine then goes idle without fetching the next descriptor and without setting done.
- R12: Status bit1 (done) is cleared only by writing 1 to bit1 of csr address 2. Writing 0 leaves it set. Csr reads are combinational and csr address 1 reads back the first descriptor address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Stream beat valid |
| st_ready | output | 1 | Stream beat accepted when high with st_valid |
| st_data | input | 32 | Stream beat data |
| st_sop | input | 1 | Start-of-packet flag (ignored) |
| st_eop | input | 1 | End-of-packet flag |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete (read data valid in the same cycle) |
| mem_rdata | input | 32 | Read data |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register select: 0 control, 1 first descriptor, 2 status |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational) |

## Verification
A stream beat accepted at a clock edge puts its write request on the memory port from the very next cycle. Run, busy and done change on the edge where the last memory access of a descriptor is acknowledged. Csr reads reflect that state at once. The bench drives stimulus and samples on the falling edge, so each value has settled one half period after the edge that made it. Instead of counting fixed latencies, the bench polls the status register until busy clears, then compares the memory image. It logs the order of memory accesses to show that the write-back comes before the next descriptor read.

// File: rtl/s2m_dma_pkg.sv
package s2m_dma_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;

    // control word bit positions (decoded by software)
    localparam int OWN_BIT    = 0;
    localparam int EOPEN_BIT  = 1;
    localparam int EOPHIT_BIT = 8;
    localparam int DONE_BIT   = 9;

    localparam logic [1:0] CSR_CTRL  = 2'd0;
    localparam logic [1:0] CSR_FIRST = 2'd1;
    localparam logic [1:0] CSR_STAT  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_BEAT,
        ST_WRITE,
        ST_WBACK
    } eng_state_e;

endpackage

// File: rtl/s2m_csr.sv
module s2m_csr
    import s2m_dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    input  logic          busy,
    input  logic          chain_end,
    output logic          run,
    output logic [DW-1:0] first_addr,
    output logic          done
);

    typedef struct packed {
        logic          run;
        logic [DW-1:0] first;
        logic          done;
    } csr_regs_t;

    csr_regs_t q, d;

    always_comb begin
        d = q;
        if (csr_we && csr_addr == CSR_CTRL)  d.run   = csr_wdata[0];
        if (csr_we && csr_addr == CSR_FIRST) d.first = csr_wdata;
        if (csr_we && csr_addr == CSR_STAT && csr_wdata[1]) d.done = 1'b0;
        if (chain_end) begin
            d.run  = 1'b0;
            d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            CSR_CTRL:  csr_rdata[0] = q.run;
            CSR_FIRST: csr_rdata    = q.first;
            CSR_STAT:  csr_rdata[1:0] = {q.done, busy};
            default:   csr_rdata = '0;
        endcase
    end

    assign run        = q.run;
    assign first_addr = q.first;
    assign done       = q.done;

endmodule

// File: rtl/s2m_engine.sv
module s2m_engine
    import s2m_dma_pkg::*;
#(
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [DW-1:0] first_addr,
    input  logic          st_valid,
    input  logic [DW-1:0] st_data,
    input  logic          st_eop,
    output logic          st_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          chain_end
);

    localparam int            BEAT_BYTES = DW / 8;
    localparam logic [DW-1:0] CTRL_OFS   = DW'(3 * BEAT_BYTES);

    typedef struct packed {
        eng_state_e    st;
        logic [1:0]    idx;
        logic [DW-1:0] desc;
        logic [DW-1:0] dst;
        logic [DW-1:0] nxt;
        logic [DW-1:0] wdata;
        logic [LW-1:0] len;
        logic [LW-1:0] bytes;
        logic          eop_en;
        logic          last;
        logic          eop_end;
    } eng_regs_t;

    eng_regs_t q, d;

    logic [LW:0]   bytes_after;
    logic          eop_hit;
    logic          cnt_hit;
    logic [DW-1:0] wb_word;

    assign bytes_after = {1'b0, q.bytes} + (LW+1)'(BEAT_BYTES);
    assign eop_hit     = st_eop && (q.len == '0 || q.eop_en);
    assign cnt_hit     = (q.len != '0) && (bytes_after >= {1'b0, q.len});

    always_comb begin
        wb_word = '0;
        wb_word[DW-1 -: LW]   = q.bytes;
        wb_word[DONE_BIT]     = 1'b1;
        wb_word[EOPHIT_BIT]   = q.eop_end;
        wb_word[EOPEN_BIT]    = q.eop_en;
        wb_word[OWN_BIT]      = 1'b0;
    end

    // next-state logic
    always_comb begin
        d         = q;
        chain_end = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (run) begin
                    d.desc = first_addr;
                    d.idx  = '0;
                    d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    d.idx = q.idx + 2'd1;
                    case (q.idx)
                        2'd0: d.dst = mem_rdata;
                        2'd1: d.nxt = mem_rdata;
                        2'd2: d.len = mem_rdata[LW-1:0];
                        default: begin
                            d.eop_en  = mem_rdata[EOPEN_BIT];
                            d.bytes   = '0;
                            d.eop_end = 1'b0;
                            d.last    = 1'b0;
                            if (mem_rdata[OWN_BIT]) begin
                                d.st = ST_BEAT;
                            end else begin
                                d.st      = ST_IDLE;
                                chain_end = 1'b1;
                            end
                        end
                    endcase
                end
            end
            ST_BEAT: begin
                if (st_valid) begin
                    d.wdata   = st_data;
                    d.eop_end = eop_hit;
                    d.last    = eop_hit || cnt_hit;
                    d.st      = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    d.bytes = bytes_after[LW-1:0];
                    d.st    = q.last ? ST_WBACK : ST_BEAT;
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    if (run) begin
                        d.desc = q.nxt;
                        d.idx  = '0;
                        d.st   = ST_FETCH;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // outputs from registered state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.desc + DW'(q.idx) * DW'(BEAT_BYTES);
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.dst + DW'(q.bytes);
                mem_wdata = q.wdata;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.desc + CTRL_OFS;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    assign st_ready = (q.st == ST_BEAT);
    assign busy     = (q.st != ST_IDLE);

endmodule

// File: rtl/s2m_dma_writer.sv
module s2m_dma_writer
    import s2m_dma_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int LEN_W_P = LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_sop,
    input  logic              st_eop,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              csr_we,
    input  logic [1:0]        csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata
);

    logic              eng_busy;
    logic              chain_end;
    logic              run;
    logic              done_flag;
    logic [DATA_W-1:0] first_addr;
    logic              sop_unused;

    // start-of-packet carries no meaning for this engine
    assign sop_unused = st_sop;

    s2m_csr #(.DW(DATA_W)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .busy       (eng_busy),
        .chain_end  (chain_end),
        .run        (run),
        .first_addr (first_addr),
        .done       (done_flag)
    );

    s2m_engine #(.DW(DATA_W), .LW(LEN_W_P)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .first_addr (first_addr),
        .st_valid   (st_valid),
        .st_data    (st_data),
        .st_eop     (st_eop),
        .st_ready   (st_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .busy       (eng_busy),
        .chain_end  (chain_end)
    );

endmodule

// File: rtl/s2m_dma_writer_chk.sv
module s2m_dma_writer_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          st_valid,
    input logic          st_ready,
    input logic [DW-1:0] st_data,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          busy,
    input logic          done
);

    // R4
    ready_excl_write_chk: assert property (@(posedge clk) disable iff (rst)
        st_ready |-> !mem_req);

    // R4
    beat_to_write_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready) |=> (mem_req && mem_we && mem_wdata == $past(st_data)));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !st_ready));

    // R3
    done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy);

endmodule

bind s2m_dma_writer s2m_dma_writer_chk #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_data   (st_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (eng_busy),
    .done      (done_flag)
);

// File: tb/s2m_dma_writer_test.sv
`timescale 1ns/1ps
module s2m_dma_writer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_data = '0;
    logic        st_sop = 1'b0;
    logic        st_eop = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    int acc_n = 0;
    int wb_pos = -1;
    int rd_pos = -1;
    logic [31:0] wb_watch = 32'h4C;
    logic [31:0] rd_watch = 32'h80;

    always #5 clk = ~clk;

    s2m_dma_writer uut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .st_sop(st_sop), .st_eop(st_eop),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata)
    );

    // memory responder: ack one cycle after a request is seen
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                acc_n <= acc_n + 1;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    if (mem_addr == wb_watch) wb_pos <= acc_n;
                end else begin
                    mem_rdata <= mem[mem_addr[9:2]];
                    if (mem_addr == rd_watch) rd_pos <= acc_n;
                end
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            errors = errors + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        csr_addr = a;
        #1 v = csr_rdata;
    endtask

    task automatic send_beat(input logic [31:0] d, input logic e, input logic s);
        @(negedge clk);
        st_valid = 1'b1; st_data = d; st_eop = e; st_sop = s;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0; st_eop = 1'b0; st_sop = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            csr_read(2'd2, s);
            if (!s[0]) break;
        end
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (st_ready) break;
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD0000 + 32'(i);
    endtask

    task automatic put_desc(input int waddr, input logic [31:0] dst, input logic [31:0] nxt,
                            input logic [31:0] len, input logic [31:0] ctl);
        mem[waddr]   = dst;
        mem[waddr+1] = nxt;
        mem[waddr+2] = len;
        mem[waddr+3] = ctl;
    endtask

    function automatic logic [31:0] wb_word(input int nbytes, input bit flag, input bit en);
        return {16'(nbytes), 6'd0, 1'b1, flag, 6'd0, en, 1'b0};
    endfunction

    typedef struct packed {
        logic [15:0] len;
        logic        en;
        logic [2:0]  nb;
        logic [3:0]  eop_m;
        logic [3:0]  sop_m;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{len: 16'd0,  en: 1'b0, nb: 3'd3, eop_m: 4'b0100, sop_m: 4'b0001}, // R5
        '{len: 16'd16, en: 1'b0, nb: 3'd4, eop_m: 4'b0000, sop_m: 4'b0000}, // R6 count
        '{len: 16'd16, en: 1'b1, nb: 3'd2, eop_m: 4'b0010, sop_m: 4'b0000}, // R6 early
        '{len: 16'd12, en: 1'b0, nb: 3'd3, eop_m: 4'b0010, sop_m: 4'b0000}, // R6 ignored
        '{len: 16'd0,  en: 1'b1, nb: 3'd1, eop_m: 4'b0001, sop_m: 4'b0001}, // R5
        '{len: 16'd10, en: 1'b0, nb: 3'd3, eop_m: 4'b0000, sop_m: 4'b0110}  // R7
    };

    initial begin
        logic [31:0] r;
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(st_ready == 1'b0, "R1 st_ready", 32'(st_ready), 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'h0);
        csr_read(2'd2, r);
        chk(r == 32'h0, "R1 status", r, 32'h0);
        csr_read(2'd0, r);
        chk(r == 32'h0, "R1 control", r, 32'h0);

        // vector table: one data descriptor then a terminating one
        for (int v = 0; v < NV; v++) begin
            int nb;
            bit flag;
            clear_mem();
            nb = int'(VECS[v].nb);
            flag = VECS[v].eop_m[nb-1] && (VECS[v].len == 16'd0 || VECS[v].en);
            put_desc(16, 32'h100, 32'h80, 32'(VECS[v].len), {30'd0, VECS[v].en, 1'b1});
            put_desc(32, 32'h180, 32'hC0, 32'd4, 32'h0);
            csr_write(2'd1, 32'h40);
            csr_write(2'd0, 32'h1);
            for (int b = 0; b < nb; b++)
                send_beat(32'hA0000000 + 32'(v*16 + b), VECS[v].eop_m[b], VECS[v].sop_m[b]);
            wait_idle();
            for (int b = 0; b < nb; b++)
                chk(mem[64+b] == 32'hA0000000 + 32'(v*16 + b), "R4 R5 R6 R7 data word",
                    mem[64+b], 32'hA0000000 + 32'(v*16 + b));
            chk(mem[64+nb] == 32'hDEAD0000 + 32'(64+nb), "R6 no write past end",
                mem[64+nb], 32'hDEAD0000 + 32'(64+nb));
            chk(mem[19] == wb_word(nb*4, flag, VECS[v].en), "R9 write-back word",
                mem[19], wb_word(nb*4, flag, VECS[v].en));
            csr_read(2'd2, r);
            chk(r[1:0] == 2'b10, "R3 done after chain", r, 32'h2);
            csr_read(2'd0, r);
            chk(r[0] == 1'b0, "R3 run cleared", r, 32'h0);
            csr_write(2'd2, 32'h2);
        end

        // R8: start with no data; engine waits
        clear_mem();
        put_desc(16, 32'h100, 32'h80, 32'd4, 32'h1);
        put_desc(32, 32'h180, 32'hC0, 32'd4, 32'h0);
        csr_write(2'd1, 32'h40);
        csr_write(2'd0, 32'h1);
        repeat (40) @(negedge clk);
        csr_read(2'd2, r);
        chk(r[0] == 1'b1, "R8 busy while waiting", r, 32'h1);
        chk(st_ready == 1'b1, "R8 ready while waiting", 32'(st_ready), 32'h1);
        chk(mem_req == 1'b0, "R8 no access while waiting", 32'(mem_req), 32'h0);
        send_beat(32'h5EED0001, 1'b0, 1'b0);
        wait_idle();
        chk(mem[64] == 32'h5EED0001, "R8 data after wait", mem[64], 32'h5EED0001);

        // R12: done clear needs a 1 in bit1
        csr_write(2'd2, 32'h0);
        csr_read(2'd2, r);
        chk(r[1] == 1'b1, "R12 done kept on write 0", r, 32'h2);
        csr_write(2'd2, 32'h2);
        csr_read(2'd2, r);
        chk(r[1] == 1'b0, "R12 done cleared on write 1", r, 32'h0);
        csr_read(2'd1, r);
        chk(r == 32'h40, "R12 first address readback", r, 32'h40);

        // R10 / R9 ordering: two data descriptors
        clear_mem();
        put_desc(16, 32'h100, 32'h80, 32'd4, 32'h1);
        put_desc(32, 32'h180, 32'hC0, 32'd8, 32'h1);
        put_desc(48, 32'h1C0, 32'h0, 32'd4, 32'h0);
        csr_write(2'd0, 32'h1);
        send_beat(32'hC0DE0000, 1'b0, 1'b0);
        send_beat(32'hC0DE0001, 1'b0, 1'b1);
        send_beat(32'hC0DE0002, 1'b1, 1'b0);
        wait_idle();
        chk(mem[64] == 32'hC0DE0000, "R10 first buffer", mem[64], 32'hC0DE0000);
        chk(mem[96] == 32'hC0DE0001, "R10 second buffer w0", mem[96], 32'hC0DE0001);
        chk(mem[97] == 32'hC0DE0002, "R10 second buffer w1", mem[97], 32'hC0DE0002);
        chk(mem[35] == wb_word(8, 1'b0, 1'b0), "R10 second write-back", mem[35], wb_word(8, 1'b0, 1'b0));
        chk(wb_pos >= 0 && wb_pos < rd_pos, "R9 write-back before next fetch",
            32'(wb_pos), 32'(rd_pos));
        csr_write(2'd2, 32'h2);

        // R11: clear run mid-descriptor
        clear_mem();
        put_desc(16, 32'h100, 32'h80, 32'd4, 32'h1);
        put_desc(32, 32'h180, 32'hC0, 32'd8, 32'h1);
        put_desc(48, 32'h1C0, 32'h0, 32'd4, 32'h0);
        csr_write(2'd0, 32'h1);
        wait_ready();
        csr_write(2'd0, 32'h0);
        send_beat(32'hFACE0000, 1'b0, 1'b0);
        wait_idle();
        chk(mem[64] == 32'hFACE0000, "R11 current finishes", mem[64], 32'hFACE0000);
        chk(mem[19] == wb_word(4, 1'b0, 1'b0), "R11 write-back done", mem[19], wb_word(4, 1'b0, 1'b0));
        chk(mem[35] == 32'h1, "R11 next untouched", mem[35], 32'h1);
        chk(mem[96] == 32'hDEAD0060, "R11 next buffer untouched", mem[96], 32'hDEAD0060);
        csr_read(2'd2, r);
        chk(r[1:0] == 2'b00, "R11 idle, done clear", r, 32'h0);

        // R3: first descriptor not owned
        clear_mem();
        put_desc(48, 32'h100, 32'h0, 32'd4, 32'h0);
        csr_write(2'd1, 32'hC0);
        csr_write(2'd0, 32'h1);
        wait_idle();
        csr_read(2'd2, r);
        chk(r[1:0] == 2'b10, "R3 done, not busy", r, 32'h2);
        csr_read(2'd0, r);
        chk(r[0] == 1'b0, "R3 run cleared", r, 32'h0);
        chk(mem[51] == 32'h0, "R3 no write-back", mem[51], 32'h0);
        chk(mem[64] == 32'hDEAD0040, "R3 no data written", mem[64], 32'hDEAD0040);

        finished = 1;
        summary();
        $finish;
    end

endmodule